// File: doc/BRIEF.md
# MDIO Management Interface Master

This block runs register access frames toward an external Ethernet PHY over the two-wire management interface. It is clocked by a fast system clock and produces the management clock (MDC) itself, by counting a programmable number of system cycles for the low phase and for the high phase of every bit. Outside a transaction MDC rests low, because the line has no upper limit on its high or low time.

A host places a PHY address, a register address, a read/write select and the write data on its inputs, then pulses a start strobe for one cycle. The block shifts out a 64-bit frame, most significant bit first: 32 preamble ones, start pattern 01, opcode (01 for a write, 10 for a read), the 5-bit PHY address, the 5-bit register address, a 2-bit turnaround field (10 on a write) and 16 data bits. On a read, the block releases the data line for the turnaround and data bits and collects the PHY's 16-bit reply. A one-cycle done pulse marks the end of every frame. The read data output holds the reply from that point on.

The phase counts are parameters. An elaboration check compares the resulting times against the minimum high time, minimum low time and minimum period at the configured system clock period.

Top module: `mdio_master`

## Requirements
- R1: After reset, and between transactions, `mdc` is low, `mdioOe` is low and `done` is low. `rdData` resets to zero.
- R2: A write frame (`isRead`=0) presents 64 bits on `mdioOut`, most significant first, one bit per MDC period: 32 ones, 01, opcode 01, `phyAddr[4:0]`, `regAddr[4:0]`, turnaround 10, then `wrData[15:0]`. `mdioOe` is high for all 64 bits.
- R3: A read frame (`isRead`=1) presents the same first 46 bits with opcode 10. `mdioOe` is high for frame bits 0 to 45 and low for bits 46 to 63, which are the turnaround and data bits.
- R4: On a read, `mdioIn` is sampled at the rising MDC edge of frame bits 48 to 63. The first sampled bit becomes `rdData[15]`. `rdData` holds the complete value when `done` pulses.
- R5: Every high phase of MDC lasts exactly HIGH_CNT system cycles. Every low phase between two bits of a frame lasts exactly LOW_CNT system cycles. With the default parameters this gives 180 ns high, 240 ns low and a 420 ns period at 20 ns per cycle.
- R6: `mdioOut` changes only at the start of an MDC low phase. It stays stable while MDC is high.
- R7: `done` is high for exactly one system cycle, in the cycle after the last high phase ends. MDC is low in that cycle. `done` occurs once per frame.
- R8: A start pulse that arrives while a frame is running is ignored. The running frame completes unchanged, and no second frame follows.
- R9: Elaboration fails if HIGH_CNT or LOW_CNT cycles fall below 160 ns, or if their sum falls below 400 ns, at the given system clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a frame |
| isRead | input | 1 | 1 selects a read frame, 0 a write frame |
| phyAddr | input | 5 | Target PHY address |
| regAddr | input | 5 | Target register address |
| wrData | input | 16 | Data for a write frame |
| rdData | output | 16 | Data returned by the last read frame |
| done | output | 1 | One-cycle pulse at the end of a frame |
| mdc | output | 1 | Management data clock |
| mdioOut | output | 1 | Management data driven toward the PHY |
| mdioOe | output | 1 | Output enable for `mdioOut` |
| mdioIn | input | 1 | Management data received from the PHY |

## Verification
The bench models a PHY that records the line at every rising MDC edge and drives reply bits after falling edges. It then compares whole frames bit for bit. A design with a shifted or reordered field, a wrong opcode or an enable that releases one bit late would show a mismatch in the captured frame or enable pattern.

The bench measures every MDC phase in system cycles. An off-by-one phase counter shows up as a high or low length that differs from the parameter. Read replies use patterns with only the top bit or only the bottom bit set, which expose an off-by-one capture or reversed bit order.

A start pulse is issued in the middle of a frame. A design that restarts, or that queues that request, would corrupt the frame, pulse `done` twice or keep toggling MDC afterwards.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int FRAME_BITS = 64;
  localparam int TA_POS     = 46;  // first turnaround bit index
  localparam int DATA_POS   = 48;  // first data bit index
  localparam int DATA_BITS  = 16;
  localparam int ADDR_BITS  = 5;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture host request into frame register
    logic shift;    // advance to next frame bit (falling MDC)
    logic sample;   // take mdioIn into read data (rising MDC)
    logic driveEn;  // master owns the data line
  } mdioStrobe_t;

endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int SYS_CLK_NS = 20,
  parameter int HIGH_CNT   = 9,
  parameter int LOW_CNT    = 12,
  parameter int MIN_HI_NS  = 160,
  parameter int MIN_LO_NS  = 160,
  parameter int MIN_PER_NS = 400
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        isRead,
  output mdioStrobe_t strb,
  output logic        mdc,
  output logic        done
);

  localparam int MIN_HI_CYC  = (MIN_HI_NS + SYS_CLK_NS - 1) / SYS_CLK_NS;
  localparam int MIN_LO_CYC  = (MIN_LO_NS + SYS_CLK_NS - 1) / SYS_CLK_NS;
  localparam int MIN_PER_CYC = (MIN_PER_NS + SYS_CLK_NS - 1) / SYS_CLK_NS;
  localparam int MAX_CNT     = (HIGH_CNT > LOW_CNT) ? HIGH_CNT : LOW_CNT;
  localparam int TW          = $clog2(MAX_CNT + 1);
  localparam int RW          = $clog2(MIN_PER_CYC + HIGH_CNT + LOW_CNT + 2) + 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  // R9: refuse configurations that break the MDC timing limits
  if (HIGH_CNT < MIN_HI_CYC) begin : g_hi_bad
    $error("mdio_ctrl: HIGH_CNT too small for minimum high time");
  end
  if (LOW_CNT < MIN_LO_CYC) begin : g_lo_bad
    $error("mdio_ctrl: LOW_CNT too small for minimum low time");
  end
  if (HIGH_CNT + LOW_CNT < MIN_PER_CYC) begin : g_per_bad
    $error("mdio_ctrl: HIGH_CNT + LOW_CNT too small for minimum period");
  end

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} phase_e;

  phase_e           phase;
  logic [TW-1:0]    timer;
  logic [IDX_W-1:0] bitIdx;
  logic             readQ;
  logic             mdcQ;
  logic             doneQ;

  wire timerZero = (timer == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= S_IDLE;
      timer  <= '0;
      bitIdx <= '0;
      readQ  <= 1'b0;
      mdcQ   <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (phase)
        S_IDLE: begin
          if (start) begin
            phase  <= S_LOW;
            timer  <= TW'(LOW_CNT - 1);
            bitIdx <= '0;
            readQ  <= isRead;
          end
        end
        S_LOW: begin
          if (timerZero) begin
            phase <= S_HIGH;
            mdcQ  <= 1'b1;
            timer <= TW'(HIGH_CNT - 1);
          end else begin
            timer <= timer - 1'b1;
          end
        end
        S_HIGH: begin
          if (timerZero) begin
            mdcQ <= 1'b0;
            if (bitIdx == LAST_IDX) begin
              phase <= S_IDLE;
              doneQ <= 1'b1;
            end else begin
              phase  <= S_LOW;
              timer  <= TW'(LOW_CNT - 1);
              bitIdx <= bitIdx + 1'b1;
            end
          end else begin
            timer <= timer - 1'b1;
          end
        end
        default: phase <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load    = (phase == S_IDLE) && start;
    strb.shift   = (phase == S_HIGH) && timerZero && (bitIdx != LAST_IDX);
    strb.sample  = (phase == S_LOW) && timerZero && readQ &&
                   (bitIdx >= IDX_W'(DATA_POS));
    strb.driveEn = (phase != S_IDLE) &&
                   !(readQ && (bitIdx >= IDX_W'(TA_POS)));
  end

  assign mdc  = mdcQ;
  assign done = doneQ;

  // ---------------- timing checks ----------------
  logic          mdcSeen;
  logic [RW-1:0] runLen;
  logic [RW-1:0] lastHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mdcSeen <= 1'b0;
      runLen  <= '0;
      lastHi  <= '0;
    end else begin
      mdcSeen <= mdcQ;
      if (mdcQ != mdcSeen)   runLen <= RW'(1);
      else if (runLen != '1) runLen <= runLen + 1'b1;
      if (mdcSeen && !mdcQ)  lastHi <= runLen;
    end
  end

  // R5
  min_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mdcQ) |-> (int'(runLen) >= MIN_HI_CYC));

  // R5
  min_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdcQ) |-> (int'(runLen) >= MIN_LO_CYC));

  // R5
  min_period_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(mdcQ) && (bitIdx != '0)) |-> (int'(runLen) + int'(lastHi) >= MIN_PER_CYC));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  // R7
  done_mdc_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> !mdcQ);

endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  mdioStrobe_t          strb,
  input  logic                 isRead,
  input  logic [ADDR_BITS-1:0] phyAddr,
  input  logic [ADDR_BITS-1:0] regAddr,
  input  logic [DATA_BITS-1:0] wrData,
  input  logic                 mdioIn,
  output logic                 mdioOut,
  output logic [DATA_BITS-1:0] rdData
);

  localparam int PRE_BITS = FRAME_BITS - 2 - 2 - 2*ADDR_BITS - 2 - DATA_BITS;

  logic [FRAME_BITS-1:0] frameQ;
  logic [FRAME_BITS-1:0] frameNew;
  logic [DATA_BITS-1:0]  rdQ;

  always_comb begin
    frameNew = {
      {PRE_BITS{1'b1}},
      2'b01,
      (isRead ? 2'b10 : 2'b01),
      phyAddr,
      regAddr,
      (isRead ? 2'b11 : 2'b10),
      (isRead ? {DATA_BITS{1'b1}} : wrData)
    };
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameQ <= '1;
      rdQ    <= '0;
    end else begin
      if (strb.load)       frameQ <= frameNew;
      else if (strb.shift) frameQ <= {frameQ[FRAME_BITS-2:0], 1'b1};
      if (strb.load)        rdQ <= '0;
      else if (strb.sample) rdQ <= {rdQ[DATA_BITS-2:0], mdioIn};
    end
  end

  assign mdioOut = frameQ[FRAME_BITS-1];
  assign rdData  = rdQ;

  // R3
  read_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.sample |-> !strb.driveEn);

  // R8
  load_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> !(strb.shift || strb.sample));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int SYS_CLK_NS = 20,
  parameter int HIGH_CNT   = 9,
  parameter int LOW_CNT    = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        isRead,
  input  logic [4:0]  phyAddr,
  input  logic [4:0]  regAddr,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  output logic        done,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);

  mdioStrobe_t strb;

  mdio_ctrl #(
    .SYS_CLK_NS (SYS_CLK_NS),
    .HIGH_CNT   (HIGH_CNT),
    .LOW_CNT    (LOW_CNT)
  ) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .isRead (isRead),
    .strb   (strb),
    .mdc    (mdc),
    .done   (done)
  );

  mdio_dp i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .isRead  (isRead),
    .phyAddr (phyAddr),
    .regAddr (regAddr),
    .wrData  (wrData),
    .mdioIn  (mdioIn),
    .mdioOut (mdioOut),
    .rdData  (rdData)
  );

  assign mdioOe = strb.driveEn;

  // R6
  data_stable_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mdc && $past(mdc)) |-> $stable(mdioOut));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!mdc && !mdioOe));

endmodule

// File: tb/test_mdio_master.sv
module test_mdio_master;

  logic        clk = 1'b0;
  logic        rstN, start, isRead;
  logic [4:0]  phyAddr, regAddr;
  logic [15:0] wrData, rdData;
  logic        done, mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  localparam int HI = 9;
  localparam int LO = 12;

  always #10 clk = ~clk;

  mdio_master #(.SYS_CLK_NS(20), .HIGH_CNT(HI), .LOW_CNT(LO)) i_mdio_master (
    .clk(clk), .rstN(rstN), .start(start), .isRead(isRead),
    .phyAddr(phyAddr), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .done(done), .mdc(mdc), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------- PHY model ----------
  int          bitCnt = 0;
  logic [63:0] seenOut, seenOe;
  logic [15:0] resp = '0;

  always @(posedge mdc) begin
    if (bitCnt < 64) begin
      seenOut[63-bitCnt] = mdioOut;
      seenOe[63-bitCnt]  = mdioOe;
    end
    bitCnt++;
  end

  always @(negedge mdc) begin
    if (bitCnt >= 48 && bitCnt < 64) mdioIn = resp[63-bitCnt];
    else if (bitCnt == 47)           mdioIn = 1'b0;
    else                             mdioIn = 1'b1;
  end

  // ---------- timing monitor ----------
  logic prevMdc = 1'b0, prevOut = 1'b1, prevDone = 1'b0;
  int   run = 0;
  bit   fromFall = 0;
  int   hiMin, hiMax, loMin, loMax, highChange, doneCnt, doneWide;

  task automatic clearStats();
    hiMin = 1000000; hiMax = 0; loMin = 1000000; loMax = 0;
    highChange = 0; doneCnt = 0; doneWide = 0; fromFall = 0;
  endtask

  always @(negedge clk) begin
    if (mdc !== prevMdc) begin
      if (prevMdc) begin
        if (run < hiMin) hiMin = run;
        if (run > hiMax) hiMax = run;
        fromFall = 1;
      end else if (fromFall) begin
        if (run < loMin) loMin = run;
        if (run > loMax) loMax = run;
      end
      run = 1;
    end else begin
      run++;
      if (mdc && (mdioOut !== prevOut)) highChange++;
    end
    if (done) doneCnt++;
    if (done && prevDone) doneWide++;
    prevMdc  = mdc;
    prevOut  = mdioOut;
    prevDone = done;
  end

  function automatic logic [63:0] frameOf(input bit rd, input logic [4:0] pa,
                                           input logic [4:0] ra, input logic [15:0] wd);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), pa, ra, 2'b10, wd};
  endfunction

  task automatic launch(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                        input logic [15:0] wd, input logic [15:0] rsp);
    resp   = rsp;
    bitCnt = 0;
    clearStats();
    @(negedge clk);
    start = 1'b1; isRead = rd; phyAddr = pa; regAddr = ra; wrData = wd;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(input string req);
    int n = 0;
    while (!done && n < 4000) begin
      @(negedge clk);
      n++;
    end
    check(done === 1'b1, req, "done seen", done, 1);
  endtask

  // ---------- scenarios ----------
  task automatic testReset();
    check(mdc === 1'b0,     "R1", "mdc after reset", mdc, 0);
    check(mdioOe === 1'b0,  "R1", "oe after reset", mdioOe, 0);
    check(done === 1'b0,    "R1", "done after reset", done, 0);
    check(rdData === 16'h0, "R1", "rdData after reset", rdData, 0);
    repeat (30) @(negedge clk);
    check(mdc === 1'b0 && bitCnt == 0, "R1", "no mdc edges while idle", bitCnt, 0);
  endtask

  task automatic testWrite(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd);
    logic [63:0] exp;
    exp = frameOf(0, pa, ra, wd);
    launch(0, pa, ra, wd, 16'h0);
    waitDone("R7");
    check(mdc === 1'b0,   "R7", "mdc low at done", mdc, 0);
    check(mdioOe === 1'b0, "R1", "oe low at done", mdioOe, 0);
    @(negedge clk);
    check(done === 1'b0, "R7", "done lasts one cycle", done, 0);
    check(seenOut === exp, "R2", "write frame bits", seenOut, exp);
    check(seenOe === 64'hFFFF_FFFF_FFFF_FFFF, "R2", "write oe pattern", seenOe,
          64'hFFFF_FFFF_FFFF_FFFF);
    check(bitCnt == 64, "R2", "write bit count", bitCnt, 64);
    check(hiMin == HI && hiMax == HI, "R5", "high length", {hiMin[31:0], hiMax[31:0]},
          {32'(HI), 32'(HI)});
    check(loMin == LO && loMax == LO, "R5", "low length", {loMin[31:0], loMax[31:0]},
          {32'(LO), 32'(LO)});
    check(highChange == 0, "R6", "data change while mdc high", highChange, 0);
    check(doneCnt == 1 && doneWide == 0, "R7", "done pulses", doneCnt, 1);
  endtask

  task automatic testRead(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] rsp);
    logic [63:0] exp;
    exp = frameOf(1, pa, ra, 16'h0);
    launch(1, pa, ra, 16'h0, rsp);
    waitDone("R7");
    check(rdData === rsp, "R4", "read data at done", rdData, rsp);
    check(seenOut[63:18] === exp[63:18], "R3", "read header bits", seenOut[63:18], exp[63:18]);
    check(seenOe === {{46{1'b1}}, 18'h0}, "R3", "read oe pattern", seenOe, {{46{1'b1}}, 18'h0});
    check(highChange == 0, "R6", "data change while mdc high", highChange, 0);
    check(hiMin == HI && loMin == LO, "R5", "read phase lengths", {hiMin[31:0], loMin[31:0]},
          {32'(HI), 32'(LO)});
    repeat (5) @(negedge clk);
    check(rdData === rsp, "R4", "read data held", rdData, rsp);
  endtask

  task automatic testStartIgnored();
    logic [63:0] exp;
    exp = frameOf(0, 5'h07, 5'h1E, 16'h3C5A);
    launch(0, 5'h07, 5'h1E, 16'h3C5A, 16'h0);
    repeat (500) @(negedge clk);
    start = 1'b1; isRead = 1'b1; phyAddr = 5'h18; regAddr = 5'h01; wrData = 16'hFFFF;
    @(negedge clk);
    start = 1'b0;
    isRead = 1'b0; phyAddr = 5'h07; regAddr = 5'h1E; wrData = 16'h3C5A;
    waitDone("R8");
    repeat (300) @(negedge clk);
    check(seenOut === exp, "R8", "frame unchanged by late start", seenOut, exp);
    check(bitCnt == 64, "R8", "no second frame", bitCnt, 64);
    check(doneCnt == 1, "R8", "single done", doneCnt, 1);
    check(mdc === 1'b0 && mdioOe === 1'b0, "R1", "idle after ignored start", {mdc, mdioOe}, 0);
  endtask

  // ---------- watchdog ----------
  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; isRead = 1'b0;
    phyAddr = '0; regAddr = '0; wrData = '0;
    clearStats();
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWrite(5'h11, 5'h0A, 16'hBEEF);
    testWrite(5'h00, 5'h1F, 16'h0001);
    testRead(5'h03, 5'h02, 16'hA5C3);
    testRead(5'h1F, 5'h00, 16'h8000);
    testRead(5'h0C, 5'h15, 16'h0001);
    testStartIgnored();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule